// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Master

This block runs the pins of an external cartridge bus on which eight shared AD lines carry two things in turn. During the address phase they hold the low byte of the address, and an external transparent latch captures it. During the data phase they hold the byte being read or written. The upper fourteen address bits have pins of their own, so the bus reaches a 22-bit (4 MB) space.

An internal requester hands the block one byte access at a time. Each access carries a direction, a target region, a 22-bit address and write data. For each access the block sequences the latch strobe, two active-low region selects, the read strobe and the write strobe. It then reports completion with a single-cycle done pulse that carries the byte it read. Every strobe and hold width is set in nanoseconds and turned into clock cycles from the clock-frequency parameter. Slow ROM reads therefore get a wide read strobe, and SRAM accesses stay short.

The state machine has ten states. IDLE accepts a request. PRE_LO and PRE_GAP make the select pre-pulse that comes before a CPU-area write. LATCH holds the latch strobe high with the address on AD. HOLD keeps the address on AD after the latch closes. TURN releases AD. READ holds the read strobe low. WRITE holds the write strobe low with the data on AD. RELEASE raises every strobe and select. ACK pulses done. The transitions are: IDLE to PRE_LO for a CPU-area write, IDLE to LATCH for any other request, PRE_LO to PRE_GAP to LATCH, LATCH to HOLD, HOLD to TURN for a read, HOLD to WRITE for a write, TURN to READ, READ or WRITE to RELEASE, RELEASE to ACK, and ACK to IDLE.

Top module: `cart_bus_master`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the bus is idle: `le` low, `ad_oe` low, and `oe_n`, `we_n`, `sel_a_n` and `sel_b_n` all high. A request is accepted only in a cycle where `req_valid` and `req_ready` are both high.
- R2: Every access begins with `le` high for LE_NS (2 cycles at 50 MHz), with `ad_oe` high and address bits 7..0 on `ad_out`. Bits 21..8 appear on `addr_hi`. AD then stays driven with the address for HOLD_NS (2 cycles) after `le` falls.
- R3: Region encoding on `req_region`: 0 and 3 select ROM, with both selects high. 1 selects SRAM, with `sel_a_n` low. 2 selects the CPU-internal area, with `sel_b_n` low. The select is held through the strobe and released before done. The two selects are never low together.
- R4: A read releases AD (`ad_oe` low) at least one cycle before `oe_n` falls. It holds `oe_n` low for ROM_RD_NS (150 cycles) in regions 0 and 3, and for RAM_RD_NS (6 cycles) in regions 1 and 2. `rdata` is the value on `ad_in` in the last cycle that `oe_n` is low.
- R5: A write drives `req_wdata` on `ad_out` with `ad_oe` high while `we_n` is low. `we_n` stays low for CPU_WE_NS (37 cycles) in region 2 and for SRAM_WE_NS (12 cycles) in every other region. `oe_n` stays high throughout.
- R6: A write to region 2 first holds `sel_a_n` low for PRE_NS (2 cycles), then both selects high for PRE_NS (2 cycles), and only then lowers `sel_b_n` for the access.
- R7: `done` is a single-cycle pulse. It comes exactly one cycle after the strobe returns high, and `req_ready` is low until the cycle after it.
- R8: `oe_n` and `we_n` are never low together, and `ad_oe` is never high while `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Target region (0/3 ROM, 1 SRAM, 2 CPU area) |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| done | output | 1 | Access complete pulse |
| rdata | output | 8 | Byte read by the last read access |
| ad_out | output | 8 | Value driven onto AD lines |
| ad_oe | output | 1 | AD output enable |
| ad_in | input | 8 | Value seen on AD lines |
| addr_hi | output | 14 | Address bits 21..8 |
| le | output | 1 | External latch strobe, active high |
| sel_a_n | output | 1 | SRAM select, active low |
| sel_b_n | output | 1 | CPU-area select, active low |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
The accesses cover each direction in each region. SRAM writes followed by read-backs tell apart the SRAM write and read timings and show that the stored byte returns through the shared lines. A CPU-area write and read-back separate the pre-pulse write path from a plain select. ROM reads at the lowest address, the highest address and alternating bit patterns, plus one region-3 read, show that the low byte reaches the latch and the upper bits reach `addr_hi`. They also separate the long read strobe from the short one and confirm that region 3 behaves as ROM.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef enum logic [1:0] {
        RG_ROM  = 2'd0,
        RG_SRAM = 2'd1,
        RG_CPU  = 2'd2,
        RG_ALT  = 2'd3
    } region_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_LO,
        ST_PRE_GAP,
        ST_LATCH,
        ST_HOLD,
        ST_TURN,
        ST_READ,
        ST_WRITE,
        ST_RELEASE,
        ST_ACK
    } state_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns2cyc(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/cbm_wait_timer.sv
module cbm_wait_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cbm_sel_decode.sv
module cbm_sel_decode
    import cbm_pkg::*;
(
    input  region_e region,
    input  logic    access,
    input  logic    pre_pulse,
    output logic    sel_a_n,
    output logic    sel_b_n
);
    always_comb begin
        sel_a_n = !(pre_pulse || (access && region == RG_SRAM));
        sel_b_n = !(access && !pre_pulse && region == RG_CPU);
    end
endmodule

// File: rtl/cart_bus_master.sv
module cart_bus_master
    import cbm_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned ADDR_W     = 22,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned LE_NS      = 40,
    parameter int unsigned HOLD_NS    = 40,
    parameter int unsigned PRE_NS     = 40,
    parameter int unsigned ROM_RD_NS  = 3000,
    parameter int unsigned RAM_RD_NS  = 120,
    parameter int unsigned SRAM_WE_NS = 240,
    parameter int unsigned CPU_WE_NS  = 740
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_region,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    input  logic [DATA_W-1:0]    ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                 le,
    output logic                 sel_a_n,
    output logic                 sel_b_n,
    output logic                 oe_n,
    output logic                 we_n
);
    localparam int unsigned LE_C      = ns2cyc(CLK_HZ, LE_NS);
    localparam int unsigned HOLD_C    = ns2cyc(CLK_HZ, HOLD_NS);
    localparam int unsigned PRE_C     = ns2cyc(CLK_HZ, PRE_NS);
    localparam int unsigned ROM_RD_C  = ns2cyc(CLK_HZ, ROM_RD_NS);
    localparam int unsigned RAM_RD_C  = ns2cyc(CLK_HZ, RAM_RD_NS);
    localparam int unsigned SRAM_WE_C = ns2cyc(CLK_HZ, SRAM_WE_NS);
    localparam int unsigned CPU_WE_C  = ns2cyc(CLK_HZ, CPU_WE_NS);
    localparam int unsigned SUM_C     = LE_C + HOLD_C + PRE_C + ROM_RD_C
                                      + RAM_RD_C + SRAM_WE_C + CPU_WE_C;
    localparam int unsigned TW        = $clog2(SUM_C + 1);

    state_e              state, nxt;
    logic                r_write;
    region_e             r_region;
    logic [ADDR_W-1:0]   r_addr;
    logic [DATA_W-1:0]   r_wdata;
    logic                t_load, t_exp;
    logic [TW-1:0]       t_val;
    logic                access, pre_pulse;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid)
                            nxt = (req_write && req_region == RG_CPU) ? ST_PRE_LO : ST_LATCH;
            ST_PRE_LO:  if (t_exp) nxt = ST_PRE_GAP;
            ST_PRE_GAP: if (t_exp) nxt = ST_LATCH;
            ST_LATCH:   if (t_exp) nxt = ST_HOLD;
            ST_HOLD:    if (t_exp) nxt = r_write ? ST_WRITE : ST_TURN;
            ST_TURN:    nxt = ST_READ;
            ST_READ:    if (t_exp) nxt = ST_RELEASE;
            ST_WRITE:   if (t_exp) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_ACK;
            ST_ACK:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // duration of the state being entered
    always_comb begin
        t_load = (nxt != state);
        unique case (nxt)
            ST_PRE_LO, ST_PRE_GAP: t_val = TW'(PRE_C - 1);
            ST_LATCH:              t_val = TW'(LE_C - 1);
            ST_HOLD:               t_val = TW'(HOLD_C - 1);
            ST_READ:               t_val = (r_region == RG_ROM || r_region == RG_ALT)
                                           ? TW'(ROM_RD_C - 1) : TW'(RAM_RD_C - 1);
            ST_WRITE:              t_val = (r_region == RG_CPU)
                                           ? TW'(CPU_WE_C - 1) : TW'(SRAM_WE_C - 1);
            default:               t_val = '0;
        endcase
    end

    cbm_wait_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            r_write  <= 1'b0;
            r_region <= RG_ROM;
            r_addr   <= '0;
            r_wdata  <= '0;
            rdata    <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                r_write  <= req_write;
                r_region <= region_e'(req_region);
                r_addr   <= req_addr;
                r_wdata  <= req_wdata;
            end
            if (state == ST_READ && t_exp)
                rdata <= ad_in;
        end
    end

    // outputs from state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        le        = 1'b0;
        ad_oe     = 1'b0;
        ad_out    = '0;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        access    = 1'b0;
        pre_pulse = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_PRE_LO:  pre_pulse = 1'b1;
            ST_PRE_GAP: ;
            ST_LATCH: begin
                le     = 1'b1;
                ad_oe  = 1'b1;
                ad_out = r_addr[DATA_W-1:0];
                access = 1'b1;
            end
            ST_HOLD: begin
                ad_oe  = 1'b1;
                ad_out = r_addr[DATA_W-1:0];
                access = 1'b1;
            end
            ST_TURN:    access = 1'b1;
            ST_READ: begin
                access = 1'b1;
                oe_n   = 1'b0;
            end
            ST_WRITE: begin
                access = 1'b1;
                we_n   = 1'b0;
                ad_oe  = 1'b1;
                ad_out = r_wdata;
            end
            ST_RELEASE: ;
            ST_ACK:     done = 1'b1;
            default:    ;
        endcase
    end

    assign addr_hi = r_addr[ADDR_W-1:DATA_W];

    cbm_sel_decode u_sel (
        .region    (r_region),
        .access    (access),
        .pre_pulse (pre_pulse),
        .sel_a_n   (sel_a_n),
        .sel_b_n   (sel_b_n)
    );

    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!le && !ad_oe && oe_n && we_n && sel_a_n && sel_b_n));

    // R2
    le_drives_ad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> ad_oe);

    // R3
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_a_n && !sel_b_n));

    // R4
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(ad_oe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(oe_n) && $past(we_n) && (!$past(oe_n, 2) || !$past(we_n, 2))));

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe && !oe_n));

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

endmodule

// File: tb/sim_cart_bus_master.sv
module sim_cart_bus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_region = 2'd0;
    logic [21:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata, ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = 8'hFF;
    logic [13:0] addr_hi;
    logic        le, sel_a_n, sel_b_n, oe_n, we_n;

    always #10 clk = ~clk;

    cart_bus_master u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .le(le),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .oe_n(oe_n), .we_n(we_n)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rom_fn(input int a);
        return (a & 8'hFF) ^ ((a >> 8) & 8'hFF) ^ ((a >> 16) & 8'h3F) ^ 8'h5A;
    endfunction

    function automatic int norm(input int rg);
        return (rg == 1) ? 1 : (rg == 2) ? 2 : 0;
    endfunction

    // cartridge model: external latch plus storage
    logic [21:0] lat_addr = '0;
    logic [7:0]  bus_mem [int];

    always @(negedge le) lat_addr = {addr_hi, ad_out};

    always @(negedge clk) begin
        int rg;
        int key;
        rg  = !sel_a_n ? 1 : (!sel_b_n ? 2 : 0);
        key = rg * 4194304 + int'(lat_addr);
        if (!we_n) bus_mem[key] = ad_out;
        if (!oe_n && !ad_oe)
            ad_in <= bus_mem.exists(key) ? bus_mem[key] : 8'(rom_fn(int'(lat_addr)));
        else
            ad_in <= 8'hFF;
    end

    // scoreboard
    typedef struct {
        bit wr;
        int rg;
        int addr;
        int data;
        int strobe;
    } item_t;
    item_t sbq[$];
    logic [7:0] shadow [int];

    task automatic issue(input bit wr, input int rg, input int addr, input int data);
        item_t it;
        int key;
        key = norm(rg) * 4194304 + addr;
        it.wr = wr; it.rg = rg; it.addr = addr;
        if (wr) begin
            it.data   = data;
            it.strobe = (rg == 2) ? 37 : 12;
            shadow[key] = 8'(data);
        end else begin
            it.data   = shadow.exists(key) ? int'(shadow[key]) : rom_fn(addr);
            it.strobe = (norm(rg) == 0) ? 150 : 6;
        end
        sbq.push_back(it);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_region = 2'(rg);
        req_addr   = 22'(addr);
        req_wdata  = 8'(data);
        @(negedge clk);
        req_valid  = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    int le_cnt = 0, hold_cnt = 0, oe_cnt = 0, we_cnt = 0;
    int a_rises = 0, pre_lo_cnt = 0, gap_cnt = 0, rel_gap = 0;
    bit seen_b = 0, turn_ok = 0, bad_cont = 0, bad_both = 0, prev_done = 0;
    logic [1:0] str_sel = 2'b11;
    logic [7:0] wdat = '0;
    logic p_le = 0, p_oe_n = 1, p_we_n = 1, p_sel_a = 1, p_ad_oe = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((!p_oe_n && oe_n) || (!p_we_n && we_n)) rel_gap = 0;
            else rel_gap++;
            if (le) le_cnt++;
            if (!le && ad_oe && oe_n && we_n) hold_cnt++;
            if (!oe_n) begin oe_cnt++; str_sel = {sel_a_n, sel_b_n}; end
            if (!we_n) begin we_cnt++; str_sel = {sel_a_n, sel_b_n}; wdat = ad_out; end
            if (p_oe_n && !oe_n) turn_ok = !p_ad_oe;
            if (ad_oe && !oe_n) bad_cont = 1;
            if (!oe_n && !we_n) bad_both = 1;
            if (!p_sel_a && sel_a_n) a_rises++;
            if (!sel_b_n) seen_b = 1;
            if (!sel_a_n && !seen_b && le_cnt == 0) pre_lo_cnt++;
            if (sel_a_n && sel_b_n && a_rises == 1 && !seen_b && le_cnt == 0) gap_cnt++;
            // R7 done lasts one cycle
            if (prev_done) begin
                chk(!done, "R7 done single pulse", done, 0);
                chk(req_ready, "R7 ready after done", req_ready, 1);
            end
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(0, "R7 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    logic [1:0] esel;
                    it = sbq.pop_front();
                    esel = (norm(it.rg) == 1) ? 2'b01 : (norm(it.rg) == 2) ? 2'b10 : 2'b11;
                    chk(le_cnt == 2, "R2 latch strobe width", le_cnt, 2);
                    chk(hold_cnt == 2, "R2 address hold width", hold_cnt, 2);
                    chk(int'(lat_addr) == it.addr, "R2 latched address", int'(lat_addr), it.addr);
                    chk(str_sel == esel, "R3 select during strobe", str_sel, esel);
                    chk(sel_a_n && sel_b_n, "R3 select released at done", {sel_a_n, sel_b_n}, 3);
                    chk(a_rises == ((norm(it.rg) == 1 || (it.wr && it.rg == 2)) ? 1 : 0),
                        "R3 sel_a pulse count", a_rises,
                        (norm(it.rg) == 1 || (it.wr && it.rg == 2)) ? 1 : 0);
                    if (it.wr) begin
                        chk(we_cnt == it.strobe, "R5 write strobe width", we_cnt, it.strobe);
                        chk(int'(wdat) == it.data, "R5 write data on AD", int'(wdat), it.data);
                        chk(oe_cnt == 0, "R5 no read strobe", oe_cnt, 0);
                        if (it.rg == 2) begin
                            chk(pre_lo_cnt == 2, "R6 pre-pulse low width", pre_lo_cnt, 2);
                            chk(gap_cnt == 2, "R6 pre-pulse gap width", gap_cnt, 2);
                        end
                    end else begin
                        chk(oe_cnt == it.strobe, "R4 read strobe width", oe_cnt, it.strobe);
                        chk(int'(rdata) == it.data, "R4 read data", int'(rdata), it.data);
                        chk(turn_ok, "R4 AD released before read strobe", turn_ok, 1);
                        chk(we_cnt == 0, "R4 no write strobe", we_cnt, 0);
                    end
                    chk(rel_gap == 1, "R7 done one cycle after release", rel_gap, 1);
                    chk(!req_ready, "R7 ready low at done", req_ready, 0);
                    chk(!bad_cont && !bad_both, "R8 no contention", {bad_cont, bad_both}, 0);
                end
                le_cnt = 0; hold_cnt = 0; oe_cnt = 0; we_cnt = 0;
                a_rises = 0; pre_lo_cnt = 0; gap_cnt = 0;
                seen_b = 0; turn_ok = 0; bad_cont = 0; bad_both = 0; str_sel = 2'b11;
            end
            prev_done = done;
        end
        p_le = le; p_oe_n = oe_n; p_we_n = we_n; p_sel_a = sel_a_n; p_ad_oe = ad_oe;
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!le && !ad_oe, "R1 reset le/ad_oe", {le, ad_oe}, 0);
        chk(oe_n && we_n, "R1 reset strobes", {oe_n, we_n}, 3);
        chk(sel_a_n && sel_b_n, "R1 reset selects", {sel_a_n, sel_b_n}, 3);
        chk(!done, "R1 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        issue(1, 1, 22'h001234, 8'hA5);
        issue(0, 1, 22'h001234, 0);
        issue(1, 1, 22'h007FFF, 8'h3C);
        issue(0, 1, 22'h007FFF, 0);
        issue(1, 2, 22'h00FFFF, 8'h28);
        issue(0, 2, 22'h00FFFF, 0);
        issue(0, 0, 22'h3FFFFF, 0);
        issue(0, 0, 22'h000000, 0);
        issue(0, 3, 22'h0155AA, 0);
        issue(0, 0, 22'h2AAA55, 0);

        // R1 idle levels between accesses
        chk(req_ready && !le && oe_n && we_n && sel_a_n && sel_b_n && !ad_oe,
            "R1 idle levels", {req_ready, le, oe_n, we_n}, 4'b1011);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule